// File: doc/BRIEF.md
# Operand-Tracking Computation Unit Manager

This block follows one operation from the cycle it is issued until its result has been written back. An issue stage pulses `issue_i` for one cycle together with an opcode, operand modifiers and a read mask. The block latches these, raises `busy_o`, and asks for each needed source operand with its own read request bit. A register-file side answers each request with a one-cycle go pulse. The operand value is present on that port's slice of `src_i` only during that pulse.

Once every needed operand is held, the block hands them to an embedded test ALU over a valid/ready link. When the ALU result comes back, the block raises a write request and shows the result on `dout_o`. It keeps `busy_o` high until the write go pulse arrives. Some operands are never requested: a masked port, operand A when the zero flag is set, and operand B when an immediate is supplied. For these the block uses zero or the immediate instead.

Top module: `opunit_mgr`

## Requirements
- R1: After reset, `busy_o`, every `rd_req_o` bit and `wr_req_o` are low.
- R2: `busy_o` stays low while no issue pulse arrives, and rises in the cycle after a pulse of `issue_i`. An issue pulse that arrives while `busy_o` is high is ignored, and the running operation's fields and result are unchanged.
- R3: Opcode, invert flag, zero flag, immediate and immediate-valid are sampled in the issue cycle. Later changes on those inputs do not affect the operation. `rdmask_i` is sampled in the same cycle, and the environment holds it while busy.
- R4: Each needed port's `rd_req_o` bit rises in the cycle after issue. It stays high through any number of stall cycles until that port's `rd_go_i` bit is seen. It is low from the cycle after the go pulse, and it does not rise again in that operation.
- R5: A port's operand is taken from `src_i` bits [i*W +: W] only in the cycle its go bit and request are both high. Values on `src_i` in other cycles have no effect.
- R6: No request is raised for a port whose `rdmask_i` bit is 1, for port 0 when `zero_a_i` is 1, or for port 1 when `imm_ok_i` is 1. Port 0 then counts as zero, port 1 counts as `imm_i`, and a masked port counts as zero.
- R7: `wr_req_o` stays high with a stable `dout_o` until `wr_go_i`. In the cycle after the write go pulse, `busy_o` and `wr_req_o` are both low.
- R8: The ALU applies the invert flag to operand A (A' = ~A) and then works by opcode: 1 gives A'+B+C, 2 gives A'*B (low W bits), 3 gives A' >> B. Every other opcode gives A'-B. C is port 2, or zero when there are only two ports. All arithmetic wraps at W bits.
- R9: With every read skipped and an issue pulse in cycle t, opcodes 1, 2 and 3 raise `wr_req_o` in cycle t+3+LAT. Every other opcode raises it in cycle t+2.
- R10: A two-operand ADD with its read grants delayed by 0 and 3 cycles goes from issue to `busy_o` low in at most 50 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | One-cycle issue pulse |
| op_i | input | 3 | Opcode |
| inv_a_i | input | 1 | Invert operand A |
| zero_a_i | input | 1 | Use zero for operand A |
| imm_i | input | W | Immediate value for operand B |
| imm_ok_i | input | 1 | Immediate valid |
| rdmask_i | input | NSRC | Per-port read mask, held while busy |
| rd_req_o | output | NSRC | Per-port read request |
| rd_go_i | input | NSRC | Per-port read grant pulse |
| src_i | input | NSRC*W | Packed operand data, port i at [i*W +: W] |
| wr_req_o | output | 1 | Write-back request |
| wr_go_i | input | 1 | Write-back grant pulse |
| dout_o | output | W | Result |
| busy_o | output | 1 | Operation in flight |

## Verification
Operations are tried with every skip combination: all ports read, A zeroed, B from the immediate, masked ports, and everything skipped. These show whether the request vector and the substituted values match the flags. Grant delays from zero to several cycles, different per port, show whether requests are held through stalls and dropped right after the grant. Garbage on `src_i` outside grant cycles, scrambled fields after issue, and a stray issue pulse while busy show whether capture and latching happen only in the cycles they should. Exact-cycle checks on the all-skipped path separate the zero-delay opcodes from the multi-cycle ones.

// File: rtl/opunit_mgr.sv
module opunit_mgr #(
  parameter int W    = 16,
  parameter int NSRC = 3,
  parameter int LAT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic [2:0]        op_i,
  input  logic              inv_a_i,
  input  logic              zero_a_i,
  input  logic [W-1:0]      imm_i,
  input  logic              imm_ok_i,
  input  logic [NSRC-1:0]   rdmask_i,
  output logic [NSRC-1:0]   rd_req_o,
  input  logic [NSRC-1:0]   rd_go_i,
  input  logic [NSRC*W-1:0] src_i,
  output logic              wr_req_o,
  input  logic              wr_go_i,
  output logic [W-1:0]      dout_o,
  output logic              busy_o
);
  localparam int CW = $clog2(LAT + 1);
  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_MUL = 3'd2;
  localparam logic [2:0] OP_SHR = 3'd3;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_EXEC, S_WRITE} st_t;

  st_t             st;
  logic [2:0]      op_q;
  logic            inv_q;
  logic [NSRC-1:0] pend;
  logic [W-1:0]    opnd [NSRC];
  logic [W-1:0]    res_q;
  logic [NSRC-1:0] skip;

  // ALU side
  logic            alu_busy, alu_done;
  logic [CW-1:0]   alu_cnt;
  logic [W-1:0]    alu_res;
  logic [W-1:0]    a_v, b_v, c_v, f;
  logic            zd;
  logic            ex_in_valid, ex_in_ready, ex_out_valid, ex_out_ready;
  logic [W-1:0]    ex_out_data;

  always_comb begin
    skip = rdmask_i;
    skip[0] = skip[0] | zero_a_i;
    skip[1] = skip[1] | imm_ok_i;
  end

  assign busy_o   = (st != S_IDLE);
  assign rd_req_o = (st == S_READ) ? pend : '0;
  assign wr_req_o = (st == S_WRITE);
  assign dout_o   = res_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      op_q  <= '0;
      inv_q <= 1'b0;
      pend  <= '0;
      res_q <= '0;
      for (int i = 0; i < NSRC; i++) opnd[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (issue_i) begin
          op_q  <= op_i;
          inv_q <= inv_a_i;
          pend  <= ~skip;
          for (int i = 0; i < NSRC; i++) opnd[i] <= '0;
          if (imm_ok_i) opnd[1] <= imm_i;
          st <= S_READ;
        end
        S_READ: begin
          for (int i = 0; i < NSRC; i++)
            if (rd_go_i[i] && pend[i]) begin
              opnd[i] <= src_i[i*W +: W];
              pend[i] <= 1'b0;
            end
          if (ex_in_valid && ex_in_ready) begin
            if (ex_out_valid) begin
              res_q <= ex_out_data;
              st    <= S_WRITE;
            end else begin
              st <= S_EXEC;
            end
          end
        end
        S_EXEC: if (ex_out_valid) begin
          res_q <= ex_out_data;
          st    <= S_WRITE;
        end
        S_WRITE: if (wr_go_i) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ex_in_valid  = (st == S_READ) && (pend == '0);
  assign ex_out_ready = (st == S_READ) || (st == S_EXEC);

  // built-in test ALU
  assign a_v = inv_q ? ~opnd[0] : opnd[0];
  assign b_v = opnd[1];
  generate
    if (NSRC > 2) begin : g_c
      assign c_v = opnd[2];
    end else begin : g_noc
      assign c_v = '0;
    end
  endgenerate

  always_comb begin
    case (op_q)
      OP_ADD:  f = a_v + b_v + c_v;
      OP_MUL:  f = a_v * b_v;
      OP_SHR:  f = a_v >> b_v;
      default: f = a_v - b_v;
    endcase
  end

  assign zd           = !(op_q == OP_ADD || op_q == OP_MUL || op_q == OP_SHR);
  assign ex_in_ready  = !alu_busy && !alu_done;
  assign ex_out_valid = alu_done || (ex_in_valid && ex_in_ready && zd);
  assign ex_out_data  = alu_done ? alu_res : f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alu_busy <= 1'b0;
      alu_done <= 1'b0;
      alu_cnt  <= '0;
      alu_res  <= '0;
    end else begin
      if (ex_in_valid && ex_in_ready && !zd) begin
        alu_busy <= 1'b1;
        alu_cnt  <= CW'(LAT - 1);
        alu_res  <= f;
      end else if (alu_busy) begin
        if (alu_cnt == '0) begin
          alu_busy <= 1'b0;
          alu_done <= 1'b1;
        end else begin
          alu_cnt <= alu_cnt - 1'b1;
        end
      end else if (alu_done && ex_out_ready) begin
        alu_done <= 1'b0;
      end
    end
  end

  // assertions
  a_r2_busy_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(issue_i));
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && wr_go_i) |=> (!busy_o && !wr_req_o));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_o && !wr_go_i) |=> (wr_req_o && $stable(dout_o)));
  a_r7_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req_o |-> (busy_o && rd_req_o == '0));

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_chk
      a_r4_rise_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o[i]) |-> $past(issue_i && !busy_o));
      a_r4_fall_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o[i] && rd_go_i[i]) |=> !rd_req_o[i]);
      a_r4_hold_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o[i] && !rd_go_i[i]) |=> rd_req_o[i]);
    end
  endgenerate
endmodule

// File: tb/sim_opunit_mgr.sv
module sim_opunit_mgr;
  localparam int W = 16, NSRC = 3, LAT = 3;

  logic clk = 0, rst_n = 0;
  logic issue_i = 0, inv_a_i = 0, zero_a_i = 0, imm_ok_i = 0, wr_go_i = 0;
  logic [2:0] op_i = 0;
  logic [W-1:0] imm_i = 0;
  logic [NSRC-1:0] rdmask_i = 0, rd_go_i = 0, rd_req_o;
  logic [NSRC*W-1:0] src_i = 0;
  logic wr_req_o, busy_o;
  logic [W-1:0] dout_o;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  opunit_mgr #(.W(W), .NSRC(NSRC), .LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .inv_a_i(inv_a_i),
    .zero_a_i(zero_a_i), .imm_i(imm_i), .imm_ok_i(imm_ok_i), .rdmask_i(rdmask_i),
    .rd_req_o(rd_req_o), .rd_go_i(rd_go_i), .src_i(src_i), .wr_req_o(wr_req_o),
    .wr_go_i(wr_go_i), .dout_o(dout_o), .busy_o(busy_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic        inv, za, iok;
    logic [15:0] imm, a, b, c;
    logic [2:0]  mask;
    logic [3:0]  d0, d1, d2;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 1'b0, 1'b0, 1'b0, 16'd0,  16'd5,  16'd2, 16'd0, 3'b100, 4'd0, 4'd0, 4'd0, 16'd7},
    '{3'd1, 1'b1, 1'b0, 1'b0, 16'd0,  16'd5,  16'd2, 16'd0, 3'b100, 4'd1, 4'd2, 4'd0, 16'd65532},
    '{3'd1, 1'b0, 1'b1, 1'b0, 16'd0,  16'd5,  16'd2, 16'd0, 3'b100, 4'd0, 4'd0, 4'd0, 16'd2},
    '{3'd1, 1'b0, 1'b0, 1'b1, 16'd10, 16'd5,  16'd2, 16'd0, 3'b100, 4'd2, 4'd0, 4'd0, 16'd15},
    '{3'd1, 1'b0, 1'b0, 1'b0, 16'd0,  16'd5,  16'd2, 16'd4, 3'b000, 4'd0, 4'd3, 4'd1, 16'd11},
    '{3'd2, 1'b0, 1'b0, 1'b0, 16'd0,  16'd3,  16'd4, 16'd0, 3'b100, 4'd2, 4'd0, 4'd0, 16'd12},
    '{3'd3, 1'b0, 1'b0, 1'b0, 16'd0,  16'd48, 16'd2, 16'd0, 3'b100, 4'd0, 4'd2, 4'd0, 16'd12},
    '{3'd3, 1'b0, 1'b0, 1'b0, 16'd0,  16'd13, 16'd1, 16'd0, 3'b100, 4'd5, 4'd5, 4'd0, 16'd6},
    '{3'd0, 1'b0, 1'b0, 1'b0, 16'd0,  16'd5,  16'd2, 16'd0, 3'b100, 4'd0, 4'd0, 4'd0, 16'd3},
    '{3'd7, 1'b0, 1'b0, 1'b0, 16'd0,  16'd2,  16'd5, 16'd0, 3'b100, 4'd1, 4'd0, 4'd0, 16'd65533},
    '{3'd1, 1'b0, 1'b0, 1'b0, 16'd0,  16'd5,  16'd2, 16'd9, 3'b011, 4'd0, 4'd0, 4'd2, 16'd9},
    '{3'd2, 1'b1, 1'b0, 1'b0, 16'd0,  16'd1,  16'd2, 16'd0, 3'b100, 4'd0, 4'd0, 4'd0, 16'd65532}
  };

  task automatic run_op(input vec_t v, input bit poke, output logic [W-1:0] res, output int cyc);
    logic [NSRC-1:0] need, given;
    int wc [NSRC];
    int dl [NSRC];
    logic [W-1:0] val [NSRC];
    bit done;
    need = ~v.mask & ~{1'b0, v.iok, v.za};
    dl[0] = int'(v.d0); dl[1] = int'(v.d1); dl[2] = int'(v.d2);
    val[0] = v.a; val[1] = v.b; val[2] = v.c;
    given = '0; done = 0; res = '0;
    for (int i = 0; i < NSRC; i++) wc[i] = 0;
    @(negedge clk);
    op_i = v.op; inv_a_i = v.inv; zero_a_i = v.za; imm_ok_i = v.iok; imm_i = v.imm;
    rdmask_i = v.mask; issue_i = 1;
    @(negedge clk);
    // R3: scramble issue-side fields after the issue cycle
    issue_i = 0; op_i = 3'd5; inv_a_i = ~v.inv; zero_a_i = ~v.za; imm_ok_i = ~v.iok; imm_i = 16'hbeef;
    cyc = 1;
    chk(busy_o == 1'b1, "R2 busy after issue", int'(busy_o), 1);
    chk(rd_req_o == need, "R4/R6 request vector after issue", int'(rd_req_o), int'(need));
    for (int n = 0; n < 60 && !done; n++) begin
      rd_go_i = '0; wr_go_i = 0; issue_i = 0;
      src_i = {3{16'h5a5a}};
      if (poke && n == 1) begin
        issue_i = 1; op_i = 3'd0; inv_a_i = 1; imm_i = 16'h0101;
      end
      if (wr_req_o) begin
        wr_go_i = 1; res = dout_o; done = 1;
      end else begin
        for (int i = 0; i < NSRC; i++) begin
          if (need[i] && !given[i]) begin
            chk(rd_req_o[i], "R4 request held while waiting", int'(rd_req_o[i]), 1);
            if (wc[i] == dl[i]) begin
              rd_go_i[i] = 1; src_i[i*W +: W] = val[i]; given[i] = 1;
            end else wc[i]++;
          end else if (rd_req_o[i]) begin
            chk(0, "R4/R6 unexpected request", 1, 0);
          end
        end
      end
      @(negedge clk);
      cyc++;
    end
    rd_go_i = '0; wr_go_i = 0; issue_i = 0;
    chk(done, "R7 write request reached", int'(done), 1);
    chk(!busy_o && !wr_req_o, "R7 released after write go", int'({busy_o, wr_req_o}), 0);
    rdmask_i = '0; op_i = 0; inv_a_i = 0; zero_a_i = 0; imm_ok_i = 0; imm_i = 0;
  endtask

  // all-skipped operation, checks the exact cycle of the write request
  task automatic skipped_op(input logic [2:0] op, input logic [W-1:0] imm, input int lat_exp,
                            input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    op_i = op; zero_a_i = 1; imm_ok_i = 1; imm_i = imm; rdmask_i = 3'b100; issue_i = 1;
    @(negedge clk);
    issue_i = 0; op_i = 0; imm_i = 0; zero_a_i = 0; imm_ok_i = 0;
    for (int k = 1; k < lat_exp - 1; k++) @(negedge clk);
    chk(!wr_req_o, {tag, " no write request one cycle early"}, int'(wr_req_o), 0);
    @(negedge clk);
    chk(wr_req_o, {tag, " write request on time"}, int'(wr_req_o), 1);
    chk(dout_o == exp, {tag, " result"}, int'(dout_o), int'(exp));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(wr_req_o && busy_o && dout_o == exp, "R7 request held without write go", int'(wr_req_o), 1);
    end
    wr_go_i = 1;
    @(negedge clk);
    wr_go_i = 0;
    chk(!busy_o && !wr_req_o, "R7 busy drops after write go", int'(busy_o), 0);
    rdmask_i = 0;
  endtask

  initial begin
    #(200000 * 10);
    tests++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    int cyc;
    repeat (3) @(negedge clk);
    chk(!busy_o && rd_req_o == 0 && !wr_req_o, "R1 reset state",
        int'({busy_o, rd_req_o, wr_req_o}), 0);
    rst_n = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!busy_o, "R2 busy low without issue", int'(busy_o), 0);
    end
    for (int k = 0; k < NV; k++) begin
      run_op(VEC[k], 1'b0, r, cyc);
      chk(r == VEC[k].exp, $sformatf("R8/R5 vector %0d result", k), int'(r), int'(VEC[k].exp));
    end
    // R2: stray issue while busy is ignored
    run_op('{3'd1, 1'b0, 1'b0, 1'b0, 16'd0, 16'd5, 16'd2, 16'd0, 3'b100, 4'd4, 4'd4, 4'd0, 16'd7},
           1'b1, r, cyc);
    chk(r == 16'd7, "R2 issue while busy ignored", int'(r), 7);
    // R10: grants delayed 0 and 3
    run_op('{3'd1, 1'b0, 1'b0, 1'b0, 16'd0, 16'd5, 16'd2, 16'd0, 3'b100, 4'd0, 4'd3, 4'd0, 16'd7},
           1'b0, r, cyc);
    chk(r == 16'd7, "R10 result", int'(r), 7);
    chk(cyc <= 50, "R10 cycles within bound", cyc, 50);
    // R9: exact write-request timing, all reads skipped
    skipped_op(3'd0, 16'd3, 2, 16'd65533, "R9 zero-delay");
    skipped_op(3'd1, 16'd3, 3 + LAT, 16'd3, "R9 multi-cycle");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule